// File: doc/BRIEF.md
# Match-Based Multi-Output PWM Generator

This block produces six pulse-width-modulated outputs from a single shared up-counter and a bank of seven programmable compare values. Compare value 0 defines the period: when the counter equals it on an advancing tick, the counter returns to zero. This event is called the restart. The remaining compare values place edges on the outputs. Each output is configured on its own as either a trailing-edge output, or a two-edge output that has separate compare values for its rising and its falling edge. One counter can therefore drive positive and negative pulses at the same time.

Software programs the unit through a plain write port made of an address, a data word and a strobe. Compare writes go to a holding copy first. A per-compare arm bit moves the held value into the working copy only at a restart, or at any cycle while the unit is disabled, so the waveform never changes part-way through a period. Every compare event sets a sticky flag, and a write-one-to-clear register clears these flags. The counter advances only on cycles where the external prescale tick is high.

Top module: `pwm_match_unit`

## Requirements
- R1: After reset, all six outputs and all seven flags are low, and every holding value, working value, arm bit and mode bit is zero.
- R2: While enabled, the counter advances by one only on a cycle with tick high. On a tick where it equals working compare 0 it goes to zero, so one period spans compare 0 plus one ticks.
- R3: While the enable input is low, the counter is held at zero and all outputs are low. After enable rises, every trailing-edge output stays low until the first restart.
- R4: A trailing-edge output k (1..6) goes high at each restart and goes low on the tick that ends count equal to working compare k.
- R5: A compare value larger than compare 0 never matches. A trailing-edge output with such a value stays high for the whole period.
- R6: Mode register bit k (k = 1..5) makes output k+1 a two-edge output. It goes high on a match of compare k and low on a match of compare k+1. Bit 0 and all bits above 5 are ignored, so output 1 is always trailing-edge.
- R7: A two-edge output whose rising compare is larger than its falling compare gives a negative pulse, low inside the period and high across the restart. Such an output runs alongside positive pulses on other outputs.
- R8: When an output's set and clear events fall on the same tick, the clear wins and the output ends low.
- R9: A write to a compare address changes only the holding copy. The working copy takes it at the next restart only if its arm bit is set, and that transfer clears the arm bit.
- R10: Flag i is set on every match of compare i. A write to the clear address clears the flags whose data bits are one. A match in the same cycle keeps its flag set.
- R11: Address map: 0..6 write holding compare 0..6; 7 ORs data bits 6:0 into the arm bits; 8 writes the mode bits; 9 is the flag clear. Writes to any other address have no effect.
- R12: While the enable input is low, armed compares move to the working copy on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Unit enable |
| tick | input | 1 | Prescale tick; the counter advances on cycles where it is high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| pwm_out | output | 6 | PWM outputs, bit k-1 is output k |
| irq_flags | output | 7 | Sticky match flags, bit i for compare i |

## Verification
The collision that matters most is an output's set event and its clear event landing on the same tick. The bench provokes it twice. A trailing-edge output gets a compare equal to the period, and a two-edge output gets equal rising and falling compares. In both cases the output must stay low through every period. A second same-cycle case is a flag clear written on the same tick as a match. The bench judges every case by comparing outputs and flags each cycle with a model built from the requirements.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MATCH,
    SEL_ARM,
    SEL_MODE,
    SEL_CLEAR
  } reg_sel_e;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int NUM_MATCH = 7,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [CNT_W-1:0]                    wr_data,
  input  logic                                load_ok,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]     mr_act,
  output logic [NUM_MATCH-2:0]                dual_sel,
  output logic [NUM_MATCH-1:0]                clr_mask
);

  localparam int NUM_OUT   = NUM_MATCH - 1;
  localparam int ARM_ADDR  = NUM_MATCH;
  localparam int MODE_ADDR = NUM_MATCH + 1;
  localparam int CLR_ADDR  = NUM_MATCH + 2;

  reg_sel_e                         sel;
  logic [NUM_MATCH-1:0][CNT_W-1:0]  sh_q;
  logic [NUM_MATCH-1:0]             sh_we;
  logic [NUM_MATCH-1:0]             act_ld;
  logic [NUM_MATCH-1:0]             arm_q, arm_d;
  logic                             arm_ce;
  logic [NUM_OUT-1:0]               mode_q, mode_d;
  logic                             mode_ce;

  // address decode
  always_comb begin
    sel = SEL_NONE;
    if (wr_en) begin
      if (wr_addr < ADDR_W'(NUM_MATCH))       sel = SEL_MATCH;
      else if (wr_addr == ADDR_W'(ARM_ADDR))  sel = SEL_ARM;
      else if (wr_addr == ADDR_W'(MODE_ADDR)) sel = SEL_MODE;
      else if (wr_addr == ADDR_W'(CLR_ADDR))  sel = SEL_CLEAR;
    end
  end

  // next-state logic
  always_comb begin
    for (int i = 0; i < NUM_MATCH; i++) begin
      sh_we[i]  = (sel == SEL_MATCH) && (wr_addr == ADDR_W'(i));
      act_ld[i] = load_ok && arm_q[i];
    end
    arm_d = load_ok ? '0 : arm_q;
    if (sel == SEL_ARM) arm_d = arm_d | wr_data[NUM_MATCH-1:0];
    arm_ce  = load_ok || (sel == SEL_ARM);
    mode_d  = {wr_data[NUM_OUT-1:1], 1'b0};
    mode_ce = (sel == SEL_MODE);
    clr_mask = (sel == SEL_CLEAR) ? wr_data[NUM_MATCH-1:0] : '0;
  end

  for (genvar g = 0; g < NUM_MATCH; g++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q[g]   <= '0;
        mr_act[g] <= '0;
      end else begin
        if (sh_we[g])  sh_q[g]   <= wr_data;
        if (act_ld[g]) mr_act[g] <= sh_q[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= '0;
      mode_q <= '0;
    end else begin
      if (arm_ce)  arm_q  <= arm_d;
      if (mode_ce) mode_q <= mode_d;
    end
  end

  assign dual_sel = mode_q;

  // R9
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ok |=> $stable(mr_act));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int NUM_MATCH = 7,
  parameter int CNT_W     = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            en,
  input  logic                            tick,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0] mr_act,
  output logic [NUM_MATCH-1:0]            match_vec,
  output logic                            restart
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run, cnt_ce;

  always_comb begin
    run = en && tick;
    for (int i = 0; i < NUM_MATCH; i++) begin
      match_vec[i] = run && (cnt_q == mr_act[i]);
    end
    restart = match_vec[0];
    cnt_ce  = !en || run;
    cnt_d   = (!en || restart) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= mr_act[0]);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !tick |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
  parameter int NUM_MATCH = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 restart,
  input  logic [NUM_MATCH-1:0] match_vec,
  input  logic [NUM_MATCH-2:0] dual_sel,
  output logic [NUM_MATCH-2:0] pwm_q
);

  localparam int NUM_OUT = NUM_MATCH - 1;

  logic [NUM_OUT-1:0] set_w, clr_w, out_d, out_ce;

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    always_comb begin
      set_w[j]  = dual_sel[j] ? match_vec[j] : restart;
      clr_w[j]  = match_vec[j+1];
      out_ce[j] = !en || set_w[j] || clr_w[j];
      if (!en)           out_d[j] = 1'b0;
      else if (clr_w[j]) out_d[j] = 1'b0;
      else               out_d[j] = set_w[j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pwm_q[j] <= 1'b0;
      end else if (out_ce[j]) begin
        pwm_q[j] <= out_d[j];
      end
    end

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_w[j] |=> !pwm_q[j]);

    // R4
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_q[j]) |-> $past(set_w[j]));
  end

endmodule

// File: rtl/pwm_irq_flags.sv
module pwm_irq_flags #(
  parameter int NUM_MATCH = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_MATCH-1:0] match_vec,
  input  logic [NUM_MATCH-1:0] clr_mask,
  output logic [NUM_MATCH-1:0] flags_q
);

  logic [NUM_MATCH-1:0] flags_d;
  logic                 flags_ce;

  always_comb begin
    flags_d  = (flags_q & ~clr_mask) | match_vec;
    flags_ce = (|clr_mask) || (|match_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_ce) begin
      flags_q <= flags_d;
    end
  end

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_chk
    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_vec[i] |=> flags_q[i]);
  end

endmodule

// File: rtl/pwm_match_unit.sv
module pwm_match_unit #(
  parameter int NUM_MATCH = 7,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   tick,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [CNT_W-1:0]       wr_data,
  output logic [NUM_MATCH-2:0]   pwm_out,
  output logic [NUM_MATCH-1:0]   irq_flags
);

  logic [1:0]                      rst_sync_q;
  logic                            rst_int_n;
  logic [NUM_MATCH-1:0][CNT_W-1:0] mr_act;
  logic [NUM_MATCH-2:0]            dual_sel;
  logic [NUM_MATCH-1:0]            clr_mask;
  logic [NUM_MATCH-1:0]            match_vec;
  logic                            restart;
  logic                            load_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign load_ok = restart || !en;

  pwm_regfile #(.NUM_MATCH(NUM_MATCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_ok(load_ok), .mr_act(mr_act),
    .dual_sel(dual_sel), .clr_mask(clr_mask)
  );

  pwm_timebase #(.NUM_MATCH(NUM_MATCH), .CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_int_n), .en(en), .tick(tick), .mr_act(mr_act),
    .match_vec(match_vec), .restart(restart)
  );

  pwm_outstage #(.NUM_MATCH(NUM_MATCH)) u_out (
    .clk(clk), .rst_n(rst_int_n), .en(en), .restart(restart),
    .match_vec(match_vec), .dual_sel(dual_sel), .pwm_q(pwm_out)
  );

  pwm_irq_flags #(.NUM_MATCH(NUM_MATCH)) u_irq (
    .clk(clk), .rst_n(rst_int_n), .match_vec(match_vec),
    .clr_mask(clr_mask), .flags_q(irq_flags)
  );

endmodule

// File: tb/pwm_match_unit_test.sv
module pwm_match_unit_test;

  logic        clk = 1'b0;
  logic        rst_n, en, tick, wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [5:0]  pwm_out;
  logic [6:0]  irq_flags;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  pwm_match_unit uut (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out),
    .irq_flags(irq_flags)
  );

  typedef struct {
    logic [5:0] out;
    logic [6:0] flg;
    string      tag;
  } exp_t;
  exp_t q[$];

  // model state, built from the requirements
  logic [31:0] m_sh [7];
  logic [31:0] m_act [7];
  logic [6:0]  m_arm, m_flags;
  logic [5:0]  m_mode, m_out;
  logic [31:0] m_cnt;
  string       cur_tag = "R1";

  task automatic model_step(input logic e, input logic t, input logic we,
                            input logic [3:0] a, input logic [31:0] d);
    logic [6:0] mt;
    logic       rs, ld;
    logic [5:0] no;
    exp_t       it;
    for (int i = 0; i < 7; i++) mt[i] = e && t && (m_cnt == m_act[i]);
    rs = mt[0];
    ld = rs || !e;
    for (int j = 0; j < 6; j++) begin
      logic st, cl;
      st = m_mode[j] ? mt[j] : rs;
      cl = mt[j+1];
      if (!e || cl) no[j] = 1'b0;
      else if (st)  no[j] = 1'b1;
      else          no[j] = m_out[j];
    end
    m_out = no;
    m_flags = (m_flags & ~((we && a == 4'd9) ? d[6:0] : 7'd0)) | mt;
    for (int i = 0; i < 7; i++) if (ld && m_arm[i]) m_act[i] = m_sh[i];
    m_arm = ld ? 7'd0 : m_arm;
    if (we && a == 4'd7) m_arm = m_arm | d[6:0];
    if (we && a < 4'd7) m_sh[a] = d;
    if (we && a == 4'd8) m_mode = {d[5:1], 1'b0};
    if (!e || rs)  m_cnt = 32'd0;
    else if (t)    m_cnt = m_cnt + 32'd1;
    it.out = m_out;
    it.flg = m_flags;
    it.tag = cur_tag;
    q.push_back(it);
  endtask

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic cyc(input logic e, input logic t, input logic we,
                     input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    en = e; tick = t; wr_en = we; wr_addr = a; wr_data = d;
    model_step(e, t, we, a, d);
  endtask

  task automatic run(input logic e, input int n, input int tick_every);
    for (int k = 0; k < n; k++) cyc(e, (k % tick_every) == 0, 1'b0, 4'd0, 32'd0);
  endtask

  task automatic wr(input logic e, input logic [3:0] a, input logic [31:0] d);
    cyc(e, 1'b0, 1'b1, a, d);
  endtask

  // monitor: pops and compares after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        compared++;
        if (pwm_out !== e.out) begin
          mismatched++;
          $display("FAIL %s pwm_out actual %b expected %b", e.tag, pwm_out, e.out);
        end
        compared++;
        if (irq_flags !== e.flg) begin
          mismatched++;
          $display("FAIL %s irq_flags actual %b expected %b", e.tag, irq_flags, e.flg);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    for (int i = 0; i < 7; i++) begin m_sh[i] = '0; m_act[i] = '0; end
    m_arm = '0; m_flags = '0; m_mode = '0; m_out = '0; m_cnt = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    compared++;
    if (pwm_out !== 6'd0) begin
      mismatched++;
      $display("FAIL R1 pwm_out actual %b expected %b", pwm_out, 6'd0);
    end
    compared++;
    if (irq_flags !== 7'd0) begin
      mismatched++;
      $display("FAIL R1 irq_flags actual %b expected %b", irq_flags, 7'd0);
    end
    rst_n = 1'b1;
    cur_tag = "R1"; run(1'b0, 4, 1);

    // R11: programming while disabled; R12: armed values move at once
    cur_tag = "R11";
    wr(1'b0, 4'd0, 32'd9);  wr(1'b0, 4'd1, 32'd3);  wr(1'b0, 4'd2, 32'd6);
    wr(1'b0, 4'd3, 32'd12); wr(1'b0, 4'd4, 32'd9);  wr(1'b0, 4'd5, 32'd2);
    wr(1'b0, 4'd6, 32'd7);  wr(1'b0, 4'd8, 32'h31);
    wr(1'b0, 4'd12, 32'd1); wr(1'b0, 4'd15, 32'hFFFF_FFFF);
    cur_tag = "R12"; wr(1'b0, 4'd7, 32'h7F);
    cur_tag = "R3";  run(1'b0, 3, 1);

    // main waveforms at full tick rate
    cur_tag = "R4"; run(1'b1, 12, 1);
    cur_tag = "R5"; run(1'b1, 12, 1);
    cur_tag = "R6"; run(1'b1, 12, 1);
    cur_tag = "R7"; run(1'b1, 12, 1);

    // R2: sparse tick
    cur_tag = "R2"; run(1'b1, 40, 3);

    // R9: holding write without arm, then with arm
    cur_tag = "R9";
    wr(1'b1, 4'd1, 32'd5);
    run(1'b1, 22, 1);
    wr(1'b1, 4'd7, 32'h02);
    run(1'b1, 22, 1);

    // R8: equal set/clear on a two-edge output
    cur_tag = "R8";
    wr(1'b1, 4'd1, 32'd4);
    wr(1'b1, 4'd2, 32'd4);
    wr(1'b1, 4'd8, 32'h32);
    wr(1'b1, 4'd7, 32'h06);
    run(1'b1, 24, 1);

    // R10: clears written on ticking cycles, then a clean clear
    cur_tag = "R10";
    for (int k = 0; k < 12; k++) cyc(1'b1, 1'b1, 1'b1, 4'd9, 32'h7F);
    cyc(1'b1, 1'b0, 1'b1, 4'd9, 32'h55);
    cyc(1'b1, 1'b0, 1'b1, 4'd9, 32'h7F);
    run(1'b1, 12, 1);

    // R3: disable mid-run, then re-enable
    cur_tag = "R3";
    run(1'b0, 5, 1);
    run(1'b1, 24, 1);

    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule